// File: doc/BRIEF.md
# Two-Program Round-Robin Task Scheduler

This block decides which instruction address is executed next in a match between two competing programs. Each program owns a circular list of task counters. Turns strictly alternate: program 0 is offered one issue, then program 1, and that pair of issues forms one match cycle. An external executor takes the issued address, runs the instruction and returns one result in the same clock cycle. The result tells the scheduler to continue at a next address, to kill the task, or to continue and also spawn a new task.

A spawned task is inserted directly after the current task, so it is the next task that program runs. The task that spawned it continues at its next address and goes to the back of the rotation. Each program holds a bounded number of tasks. The match ends when either program has no tasks left, or when the configured number of match cycles has been completed. Loading is reduced to two start addresses that are sampled while reset is held.

Top module: `duel_task_sched`

## Requirements
- R1: After reset, program 0 is offered the first issue. Issues then strictly alternate between program 0 and program 1 (`issue_prog` 0 or 1), and the turn moves on only when a result is accepted (`result_valid` high while `issue_valid` is high).
- R2: Reset (synchronous, `rst_n` low) leaves each program with exactly one task, whose counter is that program's start address. Both task counts read 1, `done` is 0 and `winner` is 0.
- R3: A program's task count never exceeds MAX_TASKS (64 by default).
- R4: A kill result (`result_kind` = 1) removes the current task. The program's count drops by one, and its next issue uses the task that followed the killed one.
- R5: A spawn result (`result_kind` = 2) on a program below the cap adds one task, and the spawn address is that program's very next issue. The spawning task continues at `result_next` after all the other tasks.
- R6: A continue result (`result_kind` = 0) replaces the current task's counter with `result_next`, and the program moves to its following task, so the tasks rotate in order.
- R7: When a program's task count reaches 0, `done` rises and `winner` names the other program (1 = program 0 wins, 2 = program 1 wins). From then until reset, `issue_valid` is low, results are ignored, and `done`, `winner` and the counts hold.
- R8: A match cycle completes when program 1's result is accepted. Once `cycle_limit` cycles have completed, `done` rises with `winner` = 3 (tie). If a program's death and the limit happen together, the death decides the winner. `winner` reads 0 while the match runs.
- R9: A spawn result arriving when the program already holds MAX_TASKS tasks is dropped. The current task continues at `result_next` exactly as for a continue, and the count stays at MAX_TASKS.
- R10: Every stored counter lies below CORE_SIZE (8000 by default). A start, next or spawn address at or above CORE_SIZE is stored reduced by CORE_SIZE.
- R11: The unused result code 3 acts exactly like a continue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; also loads the start addresses |
| start_pc0 | input | AW | First instruction address of program 0 |
| start_pc1 | input | AW | First instruction address of program 1 |
| cycle_limit | input | CYC_W | Number of match cycles before a tie is declared |
| result_valid | input | 1 | Result for the current issue is present |
| result_kind | input | 2 | 0 continue, 1 kill, 2 spawn, 3 continue |
| result_next | input | AW | Next address of the current task |
| result_spawn | input | AW | Address of the task to spawn |
| issue_valid | output | 1 | An issue is being offered |
| issue_prog | output | 1 | Program that owns the issue |
| issue_pc | output | AW | Address to execute |
| task_count0 | output | CW | Live tasks of program 0 |
| task_count1 | output | CW | Live tasks of program 1 |
| done | output | 1 | Match finished |
| winner | output | 2 | 0 running, 1 program 0, 2 program 1, 3 tie |

## Verification
The assertions check on every cycle how each result kind changes a program's task count, including the cap and the dropped spawn. They also check that a spawned address comes up next, that turns alternate, that stored counters stay below the core size, and that a finished match freezes. The full rotation order of many tasks, the behaviour of the timeout, the tie-break between death and timeout, and the reduction of out-of-range addresses can only be shown by the bench's scenarios. The bench checks these against a queue model of each program's task list.

// File: rtl/duel_sched_pkg.sv
package duel_sched_pkg;

  typedef enum logic [1:0] {
    RK_CONT  = 2'd0,
    RK_KILL  = 2'd1,
    RK_SPAWN = 2'd2,
    RK_RSVD  = 2'd3
  } res_kind_e;

  typedef enum logic [1:0] {
    WIN_NONE = 2'd0,
    WIN_P0   = 2'd1,
    WIN_P1   = 2'd2,
    WIN_TIE  = 2'd3
  } win_e;

  // Reduce an address that is below twice the modulus into [0, m).
  function automatic logic [31:0] fold_addr(input logic [31:0] a, input logic [31:0] m);
    return (a >= m) ? (a - m) : a;
  endfunction

  // Circular index step: (idx + off) mod depth, for idx < depth and off <= depth.
  function automatic logic [31:0] ring_add(input logic [31:0] idx, input logic [31:0] off,
                                           input logic [31:0] depth);
    logic [31:0] s;
    s = idx + off;
    return (s >= depth) ? (s - depth) : s;
  endfunction

endpackage

// File: rtl/duel_task_ring.sv
module duel_task_ring
  import duel_sched_pkg::*;
#(
  parameter  int CORE_SIZE = 8000,
  parameter  int MAX_TASKS = 64,
  localparam int AW = $clog2(CORE_SIZE),
  localparam int IW = $clog2(MAX_TASKS),
  localparam int CW = $clog2(MAX_TASKS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] start_pc,
  input  logic          step,
  input  res_kind_e     kind,
  input  logic [AW-1:0] next_pc,
  input  logic [AW-1:0] spawn_pc,
  output logic [AW-1:0] head_pc,
  output logic [CW-1:0] count
);

  logic [AW-1:0] slot_q [MAX_TASKS];
  logic [IW-1:0] head_q;
  logic [CW-1:0] count_q;

  logic [AW-1:0] next_w, spawn_w, start_w;
  logic [IW-1:0] tail_idx, head_inc;
  logic          full;
  logic          ev_kill, ev_spawn, ev_drop, ev_cont;

  assign next_w   = AW'(fold_addr(32'(next_pc), 32'(CORE_SIZE)));
  assign spawn_w  = AW'(fold_addr(32'(spawn_pc), 32'(CORE_SIZE)));
  assign start_w  = AW'(fold_addr(32'(start_pc), 32'(CORE_SIZE)));
  assign tail_idx = IW'(ring_add(32'(head_q), 32'(count_q), 32'(MAX_TASKS)));
  assign head_inc = IW'(ring_add(32'(head_q), 32'd1, 32'(MAX_TASKS)));
  assign full     = (count_q == CW'(MAX_TASKS));

  // Named events for the assertions
  assign ev_kill  = step && (kind == RK_KILL);
  assign ev_spawn = step && (kind == RK_SPAWN) && !full;
  assign ev_drop  = step && (kind == RK_SPAWN) && full;
  assign ev_cont  = step && !ev_kill && !ev_spawn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_TASKS; i++) slot_q[i] <= '0;
      slot_q[0] <= start_w;
      head_q    <= '0;
      count_q   <= CW'(1);
    end else if (ev_kill) begin
      head_q  <= head_inc;
      count_q <= count_q - CW'(1);
    end else if (ev_spawn) begin
      slot_q[head_q]   <= spawn_w;
      slot_q[tail_idx] <= next_w;
      count_q          <= count_q + CW'(1);
    end else if (ev_cont) begin
      slot_q[tail_idx] <= next_w;
      head_q           <= head_inc;
    end
  end

  assign head_pc = slot_q[head_q];
  assign count   = count_q;

  AST_COUNT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(MAX_TASKS)); // R3
  AST_KILL_SHRINK: assert property (@(posedge clk) disable iff (!rst_n)
    ev_kill |=> count_q == $past(count_q) - CW'(1)); // R4
  AST_SPAWN_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ev_spawn |=> (count_q == $past(count_q) + CW'(1)) && (head_pc == $past(spawn_w))); // R5
  AST_SINGLE_CONT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cont && count_q == CW'(1)) |=> head_pc == $past(next_w)); // R6
  AST_DROP_AT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_drop |=> count_q == CW'(MAX_TASKS)); // R9
  AST_PC_IN_CORE: assert property (@(posedge clk) disable iff (!rst_n)
    32'(head_pc) < 32'(CORE_SIZE)); // R10

endmodule

// File: rtl/duel_match_ctrl.sv
module duel_match_ctrl
  import duel_sched_pkg::*;
#(
  parameter int CYC_W = 20,
  parameter int CW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [CW-1:0]    cnt0,
  input  logic [CW-1:0]    cnt1,
  input  logic [CYC_W-1:0] cycle_limit,
  output logic             turn,
  output logic             done,
  output win_e             winner
);

  logic             turn_q;
  logic [CYC_W-1:0] cyc_q;
  logic             dead0, dead1, timeout;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      turn_q <= 1'b0;
      cyc_q  <= '0;
    end else if (accept) begin
      turn_q <= ~turn_q;
      if (turn_q) cyc_q <= cyc_q + CYC_W'(1);
    end
  end

  assign dead0   = (cnt0 == '0);
  assign dead1   = (cnt1 == '0);
  assign timeout = (cyc_q >= cycle_limit);

  always_comb begin
    if (dead0)        winner = WIN_P1;
    else if (dead1)   winner = WIN_P0;
    else if (timeout) winner = WIN_TIE;
    else              winner = WIN_NONE;
  end

  assign done = (winner != WIN_NONE);
  assign turn = turn_q;

  AST_TURN_ALTERNATES: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> turn_q != $past(turn_q)); // R1
  AST_CYCLE_ON_P1: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !turn_q) |=> $stable(cyc_q)); // R8

endmodule

// File: rtl/duel_task_sched.sv
module duel_task_sched
  import duel_sched_pkg::*;
#(
  parameter  int CORE_SIZE = 8000,
  parameter  int MAX_TASKS = 64,
  parameter  int CYC_W     = 20,
  localparam int AW = $clog2(CORE_SIZE),
  localparam int CW = $clog2(MAX_TASKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    start_pc0,
  input  logic [AW-1:0]    start_pc1,
  input  logic [CYC_W-1:0] cycle_limit,
  input  logic             result_valid,
  input  logic [1:0]       result_kind,
  input  logic [AW-1:0]    result_next,
  input  logic [AW-1:0]    result_spawn,
  output logic             issue_valid,
  output logic             issue_prog,
  output logic [AW-1:0]    issue_pc,
  output logic [CW-1:0]    task_count0,
  output logic [CW-1:0]    task_count1,
  output logic             done,
  output logic [1:0]       winner
);

  logic          turn, accept, done_w;
  win_e          win_w;
  res_kind_e     kind_e;
  logic [AW-1:0] head_a [2];
  logic [CW-1:0] cnt_a  [2];

  assign kind_e = res_kind_e'(result_kind);
  assign accept = issue_valid && result_valid;

  for (genvar g = 0; g < 2; g++) begin : g_prog
    logic [AW-1:0] start_sel;
    logic          step_g;
    assign start_sel = (g == 0) ? start_pc0 : start_pc1;
    assign step_g    = accept && (turn == 1'(g));

    duel_task_ring #(.CORE_SIZE(CORE_SIZE), .MAX_TASKS(MAX_TASKS)) ring_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_pc (start_sel),
      .step     (step_g),
      .kind     (kind_e),
      .next_pc  (result_next),
      .spawn_pc (result_spawn),
      .head_pc  (head_a[g]),
      .count    (cnt_a[g])
    );
  end

  duel_match_ctrl #(.CYC_W(CYC_W), .CW(CW)) ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .accept      (accept),
    .cnt0        (cnt_a[0]),
    .cnt1        (cnt_a[1]),
    .cycle_limit (cycle_limit),
    .turn        (turn),
    .done        (done_w),
    .winner      (win_w)
  );

  assign issue_valid = !done_w;
  assign issue_prog  = turn;
  assign issue_pc    = turn ? head_a[1] : head_a[0];
  assign task_count0 = cnt_a[0];
  assign task_count1 = cnt_a[1];
  assign done        = done_w;
  assign winner      = win_w;

  AST_DONE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done && $stable(winner) && $stable(task_count0) && $stable(task_count1)); // R7
  AST_ISSUE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> ((issue_prog ? task_count1 : task_count0) != '0)); // R7

endmodule

// File: tb/duel_task_sched_tb_top.sv
`timescale 1ns/1ps
module duel_task_sched_tb_top;

  localparam int CORE = 8000;
  localparam int MAXT = 64;
  localparam int CYCW = 20;
  localparam int AW   = $clog2(CORE);
  localparam int CW   = $clog2(MAXT + 1);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   start_pc0 = '0, start_pc1 = '0;
  logic [CYCW-1:0] cycle_limit = '0;
  logic            result_valid = 1'b0;
  logic [1:0]      result_kind = '0;
  logic [AW-1:0]   result_next = '0, result_spawn = '0;
  logic            issue_valid, issue_prog, done;
  logic [AW-1:0]   issue_pc;
  logic [CW-1:0]   task_count0, task_count1;
  logic [1:0]      winner;

  always #2.5 clk = ~clk;

  duel_task_sched #(.CORE_SIZE(CORE), .MAX_TASKS(MAXT), .CYC_W(CYCW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_pc0(start_pc0), .start_pc1(start_pc1),
    .cycle_limit(cycle_limit), .result_valid(result_valid), .result_kind(result_kind),
    .result_next(result_next), .result_spawn(result_spawn), .issue_valid(issue_valid),
    .issue_prog(issue_prog), .issue_pc(issue_pc), .task_count0(task_count0),
    .task_count1(task_count1), .done(done), .winner(winner)
  );

  int n_checks = 0;
  int n_err    = 0;

  // Reference model: one queue per program, front = task that runs next
  int q0[$];
  int q1[$];
  int m_turn, m_cyc, m_limit;

  function automatic int fold(int a);
    return a % CORE;
  endfunction

  function automatic int m_winner();
    if (q0.size() == 0) return 2;
    if (q1.size() == 0) return 1;
    if (m_cyc >= m_limit) return 3;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_outputs();
    int w;
    w = m_winner();
    chk(winner == 2'(w), (w == 3) ? "R8 winner code" : "R7 winner code", winner, w);
    chk(done == (w != 0), "R7 done flag", done, (w != 0));
    chk(issue_valid == (w == 0), "R7 issue_valid", issue_valid, (w == 0));
    chk(task_count0 == CW'(q0.size()), "R3 count of program 0", task_count0, q0.size());
    chk(task_count1 == CW'(q1.size()), "R3 count of program 1", task_count1, q1.size());
    if (w == 0) begin
      chk(issue_prog == 1'(m_turn), "R1 issue program", issue_prog, m_turn);
      chk(int'(issue_pc) == ((m_turn == 0) ? q0[0] : q1[0]), "R6 issue address",
          issue_pc, (m_turn == 0) ? q0[0] : q1[0]);
    end
  endtask

  task automatic model_apply(input int kind, input int nxt, input int spn);
    int sz, tmp;
    if (m_winner() != 0) return;
    sz = (m_turn == 0) ? q0.size() : q1.size();
    if (m_turn == 0) tmp = q0.pop_front(); else tmp = q1.pop_front();
    if (kind == 2 && sz < MAXT) begin
      if (m_turn == 0) q0.push_front(fold(spn)); else q1.push_front(fold(spn));
    end
    if (kind != 1) begin
      if (m_turn == 0) q0.push_back(fold(nxt)); else q1.push_back(fold(nxt));
    end
    if (m_turn == 1) m_cyc++;
    m_turn = 1 - m_turn;
  endtask

  task automatic step(input int kind, input int nxt, input int spn);
    @(negedge clk);
    compare_outputs();
    result_kind  = 2'(kind);
    result_next  = AW'(nxt);
    result_spawn = AW'(spn);
    result_valid = 1'b1;
    @(posedge clk);
    model_apply(kind, nxt, spn);
    #1;
  endtask

  task automatic do_reset(input int s0, input int s1, input int lim);
    @(negedge clk);
    rst_n = 1'b0;
    result_valid = 1'b0;
    start_pc0 = AW'(s0);
    start_pc1 = AW'(s1);
    cycle_limit = CYCW'(lim);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    q0.delete(); q1.delete();
    q0.push_back(fold(s0));
    q1.push_back(fold(s1));
    m_turn = 0; m_cyc = 0; m_limit = lim;
  endtask

  task automatic report();
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=0 expected=1");
    report();
    $finish;
  end

  initial begin : main
    int seed, kind, r;
    seed = $urandom(32'd4242);

    // R2 / R10: reset state, program 1 start wraps
    do_reset(100, 8100, 1000);
    #1;
    chk(task_count0 == 1 && task_count1 == 1, "R2 one task each", task_count0 + task_count1, 2);
    chk(done == 0 && winner == 0, "R2 not done", winner, 0);
    chk(issue_prog == 0 && issue_pc == 100, "R2 program 0 first at start", issue_pc, 100);
    step(0, 101, 0);
    chk(issue_prog == 1 && issue_pc == 100, "R10 start address reduced", issue_pc, 100);
    // R11: code 3 acts as continue
    step(3, 777, 0);
    step(0, 102, 0);
    chk(issue_pc == 777 && task_count1 == 1, "R11 reserved code continues", issue_pc, 777);
    // R5: spawn runs next for program 0, spawner goes last
    step(0, 778, 0);
    step(2, 103, 500);
    step(0, 779, 0);
    chk(issue_pc == 500 && task_count0 == 2, "R5 spawned task issued next", issue_pc, 500);
    step(0, 501, 0);
    step(0, 780, 0);
    chk(issue_pc == 103, "R5 spawner continues after others", issue_pc, 103);
    // R3 / R9: fill program 0 to the cap, then an extra spawn is dropped
    for (int i = 0; i < 70; i++) begin
      step(2, 1000 + i, 2000 + i);
      step(0, 3000 + i, 0);
    end
    chk(task_count0 == MAXT, "R9 count stays at cap", task_count0, MAXT);
    // R10: next address above core size
    step(0, 8191, 0);
    step(0, 8190, 0);
    // R4: kill one task of program 0
    step(1, 0, 0);
    chk(task_count0 == MAXT - 1, "R4 kill removes task", task_count0, MAXT - 1);
    step(0, 5, 0);
    // R7: kill program 1's single task
    step(0, 6, 0);
    step(1, 0, 0);
    chk(done == 1 && winner == 1, "R7 program 0 wins", winner, 1);
    for (int i = 0; i < 4; i++) step(2, 9, 9);
    chk(task_count1 == 0 && task_count0 == MAXT - 1, "R7 results ignored after done",
        task_count0, MAXT - 1);

    // R8: timeout after four cycles
    do_reset(10, 20, 4);
    for (int i = 0; i < 8; i++) step(0, 30 + i, 0);
    #1;
    chk(done == 1 && winner == 3, "R8 timeout tie", winner, 3);
    step(0, 1, 1);

    // R8: death on the final cycle beats the tie
    do_reset(10, 20, 3);
    for (int i = 0; i < 5; i++) step(0, 40 + i, 0);
    step(1, 0, 0);
    #1;
    chk(winner == 1, "R8 death has priority", winner, 1);

    // Random matches
    for (int m = 0; m < 6; m++) begin
      int lim;
      lim = 200 + int'($urandom % 400);
      do_reset(int'($urandom % 8192), int'($urandom % 8192), lim);
      for (int s = 0; s < 2 * lim + 4; s++) begin
        r = int'($urandom % 100);
        kind = (r < 4 + m) ? 1 : (r < 40) ? 2 : (r < 45) ? 3 : 0;
        step(kind, int'($urandom % 8192), int'($urandom % 8192));
      end
      step(0, 0, 0);
    end

    report();
    $finish;
  end

endmodule